// File: doc/BRIEF.md
# Background Pin/Buffer Transfer Engine

This engine sits beside a processor core and streams data between a 128-bit pin bus and one of two stores: a four-entry register buffer of 32-bit longs, or an external auxiliary RAM that it reaches through an address pointer. Software writes one 7-bit configuration word. The word holds an enable bit, a 3-bit mode and a 3-bit group select. From then on the engine runs a fixed clock pattern, and the pattern repeats until a new word arrives. The core takes no part in the transfer.

The eight modes cover three choices: buffer or RAM, to pins or from pins, and 16-bit or 32-bit width. Sixteen-bit modes move each long as its low half first and then its high half. A mode that reads the RAM and drives pins produces its first output one cycle later than the other modes, because the RAM has a one-cycle read latency. The buffer has its own read/write port. The RAM pointer can be loaded while the engine is idle.

Top module: `pin_xfer_engine`

## Requirements
- R1: After reset the engine is disabled. While disabled, pin_out and pin_valid are all zero and ram_re and ram_we are low.
- R2: Mode 000 (buffer to 16 pins) drives the half-long sequence entry0 low, entry0 high, entry1 low, and so on to entry3 high. It repeats every 8 clocks and begins in the cycle after the configuration write. Group p covers pins [16p+15:16p].
- R3: Mode 001 (buffer to 32 pins) drives entries 0, 1, 2 and 3 as full longs. It repeats every 4 clocks and begins in the cycle after the configuration write. Group p covers pins [32(p>>1)+31:32(p>>1)].
- R4: Mode 010 (RAM to 16 pins) produces its first output in the second cycle after the configuration write. It drives the low half of RAM[ptr], then the high half, then moves to ptr+1. In the first cycle pin_valid is zero.
- R5: Mode 011 (RAM to 32 pins) begins in the second cycle after the configuration write. It drives RAM[ptr] every clock and advances ptr by one each time, modulo 512.
- R6: Mode 100 (16 pins to buffer) samples the low half and then the high half. It writes {high, low} to entries 0 to 3 in turn, so one pass takes 8 clocks.
- R7: Mode 101 (32 pins to buffer) writes the sampled long to entries 0, 1, 2 and 3 on successive clocks.
- R8: Mode 110 (16 pins to RAM) samples the low half and then the high half. On the high-half clock only, it writes {high, low} to RAM[ptr] with ram_we and then advances ptr.
- R9: Mode 111 (32 pins to RAM) writes every clock to RAM[ptr] and advances ptr. The pointer wraps from 511 to 0.
- R10: A pointer write is accepted only while the engine is disabled. The next RAM mode then starts at the loaded address. A pointer write issued while the engine runs has no effect.
- R11: Pins outside the selected group are driven to zero. pin_valid is all ones over the active group, and only in cycles where the engine drives pins.
- R12: A configuration write while the engine runs does not cut short the operation of that cycle. In the next cycle the new mode starts from its first clock. A write with the enable bit at 0 stops the engine.
- R13: In cycles where the engine does not write the buffer, the buffer port writes entry buf_addr, and buf_rdata shows entry buf_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 7 | {enable, mode[2:0], group[2:0]} |
| ptr_we | input | 1 | RAM pointer load strobe (honoured only when idle) |
| ptr_wdata | input | 9 | Value for the RAM pointer |
| buf_we | input | 1 | Buffer write strobe |
| buf_addr | input | 2 | Buffer entry for read and write |
| buf_wdata | input | 32 | Buffer write data |
| buf_rdata | output | 32 | Buffer entry buf_addr |
| ram_re | output | 1 | RAM read request |
| ram_we | output | 1 | RAM write request |
| ram_addr | output | 9 | RAM address (current pointer) |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, valid one cycle after ram_re |
| pin_in | input | 128 | Pin input bus |
| pin_out | output | 128 | Pin output bus |
| pin_valid | output | 128 | Marks pins the engine drives this cycle |

## Verification
The phase counter picks both the buffer entry and the half of the long. An error in it shows up as a wrong word or a swapped half at the pins in the first pattern cycle that uses it, which is at most eight clocks after configuration. An error in the pointer or in the read-lag flag shows up one cycle later at ram_addr or at pin_valid. The bench compares the output every cycle against the expected sequence. For the modes that capture data, it reads back the buffer or RAM after the stop. Any wrong sample then appears in the content of the entry it should have filled.

// File: rtl/pin_xfer_engine.sv
module pin_xfer_engine #(
  parameter int LONG_W = 32,
  parameter int PIN_W  = 128,
  parameter int PTR_W  = 9,
  parameter int BUF_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [6:0]        cfg_data,
  input  logic              ptr_we,
  input  logic [PTR_W-1:0]  ptr_wdata,
  input  logic              buf_we,
  input  logic [$clog2(BUF_N)-1:0] buf_addr,
  input  logic [LONG_W-1:0] buf_wdata,
  output logic [LONG_W-1:0] buf_rdata,
  output logic              ram_re,
  output logic              ram_we,
  output logic [PTR_W-1:0]  ram_addr,
  output logic [LONG_W-1:0] ram_wdata,
  input  logic [LONG_W-1:0] ram_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_valid
);
  localparam int HALF_W = LONG_W / 2;
  localparam int BIX_W  = $clog2(BUF_N);
  localparam int SH_W   = $clog2(PIN_W) + 1;

  logic              en_q, rd_live_q, rd_half_q;
  logic [2:0]        mode_q, grp_q;
  logic [BIX_W:0]    ph_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [HALF_W-1:0] lo_q;
  logic [LONG_W-1:0] buf_q [BUF_N];

  wire to_pins = ~mode_q[2];
  wire use_ram = mode_q[1];
  wire wide    = mode_q[0];

  logic [SH_W-1:0]   sh;
  logic [PIN_W-1:0]  lane;
  logic [LONG_W-1:0] pin_word, ent16, ent32, out_word, cap_word;
  logic [BIX_W-1:0]  bidx;
  logic              drive, adv, bwe;

  always_comb begin
    sh   = wide ? SH_W'(grp_q[2:1]) * SH_W'(LONG_W) : SH_W'(grp_q) * SH_W'(HALF_W);
    lane = wide ? (PIN_W'({LONG_W{1'b1}}) << sh) : (PIN_W'({HALF_W{1'b1}}) << sh);
  end

  assign pin_word = LONG_W'(pin_in >> sh);
  assign cap_word = wide ? pin_word : {pin_word[HALF_W-1:0], lo_q};

  assign ent16 = buf_q[ph_q[BIX_W:1]];
  assign ent32 = buf_q[ph_q[BIX_W-1:0]];

  always_comb begin
    if (use_ram)
      out_word = wide ? ram_rdata
               : {{HALF_W{1'b0}}, rd_half_q ? ram_rdata[LONG_W-1:HALF_W] : ram_rdata[HALF_W-1:0]};
    else
      out_word = wide ? ent32
               : {{HALF_W{1'b0}}, ph_q[0] ? ent16[LONG_W-1:HALF_W] : ent16[HALF_W-1:0]};
  end

  assign drive     = en_q && to_pins && (!use_ram || rd_live_q);
  assign pin_out   = drive ? (PIN_W'(out_word) << sh) : '0;
  assign pin_valid = drive ? lane : '0;

  assign ram_re    = en_q && to_pins && use_ram;
  assign ram_we    = en_q && !to_pins && use_ram && (wide || ph_q[0]);
  assign ram_addr  = ptr_q;
  assign ram_wdata = cap_word;
  assign adv       = (ram_re || ram_we) && (wide || ph_q[0]);

  assign bwe  = en_q && !to_pins && !use_ram && (wide || ph_q[0]);
  assign bidx = wide ? ph_q[BIX_W-1:0] : ph_q[BIX_W:1];
  assign buf_rdata = buf_q[buf_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      mode_q    <= '0;
      grp_q     <= '0;
      ph_q      <= '0;
      rd_live_q <= 1'b0;
      rd_half_q <= 1'b0;
    end else if (cfg_we) begin
      en_q      <= cfg_data[6];
      mode_q    <= cfg_data[5:3];
      grp_q     <= cfg_data[2:0];
      ph_q      <= '0;
      rd_live_q <= 1'b0;
    end else if (en_q) begin
      ph_q      <= ph_q + 1'b1;
      rd_live_q <= ram_re;
      rd_half_q <= ph_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ptr_q <= '0;
    else if (adv)               ptr_q <= ptr_q + 1'b1;
    else if (ptr_we && !en_q)   ptr_q <= ptr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    lo_q <= '0;
    else if (en_q && !to_pins && !wide && !ph_q[0]) lo_q <= pin_word[HALF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_N; i++) buf_q[i] <= '0;
    end else if (bwe) begin
      buf_q[bidx] <= cap_word;
    end else if (buf_we) begin
      buf_q[buf_addr] <= buf_wdata;
    end
  end
endmodule

// File: rtl/pin_xfer_engine_chk.sv
module pin_xfer_engine_chk #(
  parameter int PIN_W  = 128,
  parameter int PTR_W  = 9,
  parameter int LONG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic [2:0]       mode_q,
  input logic [PTR_W-1:0] ptr_q,
  input logic             cfg_we,
  input logic             ptr_we,
  input logic             ram_re,
  input logic             ram_we,
  input logic [PTR_W-1:0] ram_addr,
  input logic [PIN_W-1:0] pin_out,
  input logic [PIN_W-1:0] pin_valid
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (pin_valid == '0 && !ram_re && !ram_we)); // R1
  AST_OUT_IN_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_valid) == '0); // R11
  AST_LANE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    pin_valid != '0 |-> ($countones(pin_valid) == LONG_W || $countones(pin_valid) == LONG_W / 2)); // R11
  AST_RAM_OUT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_valid != '0 && mode_q[2:1] == 2'b01) |-> $past(ram_re)); // R4
  AST_PTR_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && ptr_we && !ram_re && !ram_we) |=> ptr_q == $past(ptr_q)); // R10
  AST_WIDE_RAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && mode_q == 3'b111 && !cfg_we) |=> (!ram_we || ram_addr == PTR_W'($past(ram_addr) + 1'b1))); // R9
  AST_NO_DUAL_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_re && ram_we)); // R8
endmodule

bind pin_xfer_engine pin_xfer_engine_chk #(.PIN_W(PIN_W), .PTR_W(PTR_W), .LONG_W(LONG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .mode_q(mode_q), .ptr_q(ptr_q),
  .cfg_we(cfg_we), .ptr_we(ptr_we), .ram_re(ram_re), .ram_we(ram_we),
  .ram_addr(ram_addr), .pin_out(pin_out), .pin_valid(pin_valid)
);

// File: tb/sim_pin_xfer_engine.sv
`timescale 1ns/1ps
module sim_pin_xfer_engine;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, ptr_we = 0, buf_we = 0;
  logic [6:0] cfg_data = '0;
  logic [8:0] ptr_wdata = '0;
  logic [1:0] buf_addr = '0;
  logic [31:0] buf_wdata = '0, buf_rdata, ram_wdata, ram_rdata;
  logic ram_re, ram_we;
  logic [8:0] ram_addr;
  logic [127:0] pin_in = '0, pin_out, pin_valid;
  logic [31:0] mem [512];
  logic [31:0] rd_q;
  int nchk = 0, nerr = 0;
  bit finished = 0;
  localparam logic [127:0] JUNK = 128'hF00D_BEEF_1357_9BDF_2468_ACE0_DEAD_C0DE;
  logic [31:0] bv [4];

  always #5 clk = ~clk;

  pin_xfer_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .ram_re(ram_re), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_valid(pin_valid)
  );

  function automatic logic [31:0] minit(input int i);
    return (32'(i) * 32'h0101_0101) ^ 32'hA500_0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= minit(i);
      rd_q <= '0;
    end else begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      if (ram_re) rd_q <= mem[ram_addr];
    end
  end
  assign ram_rdata = rd_q;

  function automatic logic [127:0] place(input logic [31:0] w, input bit wide, input logic [2:0] p);
    if (wide) return {96'b0, w} << (32 * int'(p >> 1));
    return {112'b0, w[15:0]} << (16 * int'(p));
  endfunction
  function automatic logic [127:0] lanem(input bit wide, input logic [2:0] p);
    return place(32'hFFFF_FFFF, wide, p);
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cfg(input bit e, input logic [2:0] m, input logic [2:0] p);
    cfg_we = 1; cfg_data = {e, m, p};
    step();
    cfg_we = 0;
  endtask

  task automatic load_ptr(input logic [8:0] v);
    ptr_we = 1; ptr_wdata = v;
    step();
    ptr_we = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 pin_out", pin_out, '0);
    check("R1 pin_valid", pin_valid, '0);
    check("R1 ram_re/we", {126'b0, ram_re, ram_we}, '0);
    step();
  endtask

  task automatic t_bufport();
    for (int j = 0; j < 4; j++) begin
      bv[j] = {16'hA000 + 16'(j), 16'h5000 + 16'(j * 3)};
      buf_we = 1; buf_addr = 2'(j); buf_wdata = bv[j];
      step();
    end
    buf_we = 0;
    for (int j = 0; j < 4; j++) begin
      buf_addr = 2'(j); #1;
      check("R13 buffer readback", {96'b0, buf_rdata}, {96'b0, bv[j]});
    end
  endtask

  task automatic t_buf16();
    cfg(1, 3'b000, 3'd5);
    for (int k = 0; k < 12; k++) begin
      int e = (k % 8) / 2;
      logic [31:0] w = (k % 2) ? {16'b0, bv[e][31:16]} : {16'b0, bv[e][15:0]};
      @(negedge clk);
      check("R2 buf->16 data", pin_out, place(w, 0, 3'd5));
      check("R11 mask 16", pin_valid, lanem(0, 3'd5));
      step();
    end
    cfg(0, 3'b000, 3'd0);
    @(negedge clk);
    check("R12 stopped", pin_valid, '0);
  endtask

  task automatic t_buf32();
    cfg(1, 3'b001, 3'd5);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R3 buf->32 data", pin_out, place(bv[k % 4], 1, 3'd5));
      check("R11 mask 32", pin_valid, lanem(1, 3'd5));
      step();
    end
    cfg(0, 3'b000, 3'd0);
  endtask

  task automatic t_ram16();
    load_ptr(9'd10);
    cfg(1, 3'b010, 3'd0);
    @(negedge clk);
    check("R4 first cycle idle", pin_valid, '0);
    check("R10 loaded ptr", {119'b0, ram_addr}, 128'd10);
    step();
    for (int k = 0; k < 8; k++) begin
      logic [31:0] m = minit(10 + k / 2);
      logic [31:0] w = (k % 2) ? {16'b0, m[31:16]} : {16'b0, m[15:0]};
      @(negedge clk);
      check("R4 ram->16 data", pin_out, place(w, 0, 3'd0));
      step();
    end
    cfg(0, 3'b000, 3'd0);
  endtask

  task automatic t_ram32();
    load_ptr(9'd510);
    cfg(1, 3'b011, 3'd7);
    @(negedge clk);
    check("R5 first cycle idle", pin_valid, '0);
    step();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R5 ram->32 data", pin_out, place(minit((510 + k) % 512), 1, 3'd7));
      step();
    end
    cfg(0, 3'b000, 3'd0);
  endtask

  task automatic t_pin16buf();
    logic [15:0] v [8];
    cfg(1, 3'b100, 3'd2);
    for (int k = 0; k < 8; k++) begin
      v[k] = 16'h3000 + 16'(k * 16'h111);
      pin_in = (JUNK & ~lanem(0, 3'd2)) | place({16'b0, v[k]}, 0, 3'd2);
      if (k == 7) begin cfg_we = 1; cfg_data = '0; end
      step();
    end
    cfg_we = 0;
    for (int j = 0; j < 4; j++) begin
      buf_addr = 2'(j); #1;
      check("R6 16 pins->buffer", {96'b0, buf_rdata}, {96'b0, v[2*j+1], v[2*j]});
    end
  endtask

  task automatic t_pin32buf();
    logic [31:0] v [4];
    cfg(1, 3'b101, 3'd3);
    for (int k = 0; k < 4; k++) begin
      v[k] = 32'h7700_0000 + 32'(k) * 32'h0101_0101;
      pin_in = (JUNK & ~lanem(1, 3'd3)) | place(v[k], 1, 3'd3);
      if (k == 3) begin cfg_we = 1; cfg_data = '0; end
      step();
    end
    cfg_we = 0;
    for (int j = 0; j < 4; j++) begin
      buf_addr = 2'(j); #1;
      check("R7 32 pins->buffer", {96'b0, buf_rdata}, {96'b0, v[j]});
    end
  endtask

  task automatic t_pin16ram();
    logic [15:0] v [4];
    load_ptr(9'd100);
    cfg(1, 3'b110, 3'd1);
    for (int k = 0; k < 4; k++) begin
      v[k] = 16'h9A00 + 16'(k);
      pin_in = (JUNK & ~lanem(0, 3'd1)) | place({16'b0, v[k]}, 0, 3'd1);
      if (k == 3) begin cfg_we = 1; cfg_data = '0; end
      @(negedge clk);
      check("R8 write only on high half", {127'b0, ram_we}, 128'(k % 2));
      step();
    end
    cfg_we = 0;
    check("R8 RAM[100]", {96'b0, mem[100]}, {96'b0, v[1], v[0]});
    check("R8 RAM[101]", {96'b0, mem[101]}, {96'b0, v[3], v[2]});
  endtask

  task automatic t_pin32ram();
    logic [31:0] v [3];
    load_ptr(9'd511);
    cfg(1, 3'b111, 3'd6);
    for (int k = 0; k < 3; k++) begin
      v[k] = 32'h4242_0000 + 32'(k);
      pin_in = (JUNK & ~lanem(1, 3'd6)) | place(v[k], 1, 3'd6);
      if (k == 1) begin ptr_we = 1; ptr_wdata = 9'd5; end
      if (k == 2) begin cfg_we = 1; cfg_data = '0; end
      @(negedge clk);
      check("R9 R10 address sequence", {119'b0, ram_addr}, 128'((511 + k) % 512));
      step();
      ptr_we = 0;
    end
    cfg_we = 0;
    check("R9 RAM[511]", {96'b0, mem[511]}, {96'b0, v[0]});
    check("R9 RAM[0] wrap", {96'b0, mem[0]}, {96'b0, v[1]});
    check("R9 RAM[1]", {96'b0, mem[1]}, {96'b0, v[2]});
  endtask

  task automatic t_restart();
    for (int j = 0; j < 4; j++) begin
      buf_we = 1; buf_addr = 2'(j); buf_wdata = bv[j];
      step();
    end
    buf_we = 0;
    cfg(1, 3'b000, 3'd0);
    step(); step();
    @(negedge clk);
    check("R12 before restart", pin_out, place({16'b0, bv[1][15:0]}, 0, 3'd0));
    cfg(1, 3'b001, 3'd0);
    @(negedge clk);
    check("R12 restart entry0", pin_out, place(bv[0], 1, 3'd0));
    step();
    @(negedge clk);
    check("R12 restart entry1", pin_out, place(bv[1], 1, 3'd0));
    cfg(0, 3'b000, 3'd0);
    @(negedge clk);
    check("R12 R1 stopped out", pin_out, '0);
    check("R12 R1 stopped mask", pin_valid, '0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_bufport();
    t_buf16();
    t_buf32();
    t_ram16();
    t_ram32();
    t_pin16buf();
    t_pin32buf();
    t_pin16ram();
    t_pin32ram();
    t_bufport();
    t_restart();
    finish_run();
  end
endmodule